// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block is the digital driver logic of a current-mode multiphase buck controller. A pulse from the switching oscillator starts the on time of one phase. Successive pulses hand the on time to the following phase in a fixed rotation. A current-comparator trip ends the on time early. If no trip arrives, the next oscillator pulse ends it. In every case exactly one phase is driven per oscillator period, and the active duty is capped at one period in two or one period in three.

A select input chooses two-phase or three-phase rotation. The select input is read only when an oscillator pulse arrives. Several protection inputs override the loop and hold every output low while they are active:
- An overvoltage trip, which is latched until a separate release flag reports that the output has fallen well below nominal.
- A disable flag from a low compensation node, which also halts the rotation.
- A voltage-ID code of all ones, which means that no processor is fitted.

The oscillator, the error amplifier, the comparators and the power drivers are outside the block. They reach it as synchronous digital flags.

Top module: `mph_sequencer`

## Requirements
- R1: With `three_ph`=1, successive accepted `tick` pulses raise `pwm` bit 0, then bit 1, then bit 2, then bit 0 again. Each output change appears on the clock edge that samples the tick.
- R2: With `three_ph`=0, the rotation covers only bit 0 and bit 1, and `pwm[2]` stays low.
- R3: A `trip` in a cycle without a tick clears the active output at that edge, and the output stays low until the next tick. When `trip` and `tick` arrive together, the tick wins and the next phase is raised.
- R4: At most one bit of `pwm` is high at any time. A tick clears the previous phase on the same edge that raises the new phase.
- R5: `ov_trip` clears all `pwm` bits at the next edge, and ticks are ignored while it is high.
- R6: After an `ov_trip`, the outputs stay low and ticks are ignored until an `ov_release` is sampled while `ov_trip` is low. After that, the next tick raises the phase that was due when the override began.
- R7: While `comp_low` is high, all outputs go low at the next edge, ticks are ignored and the rotation does not advance.
- R8: A `vid` value of all ones (5'b11111) holds all outputs low and blocks ticks. Any other value has no effect on the outputs.
- R9: A change of `three_ph` takes effect at the next accepted tick, and that tick raises `pwm[0]`.
- R10: A synchronous active-low reset clears `pwm` and the overvoltage latch. The first tick after reset raises `pwm[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oscillator period pulse, one cycle wide |
| trip | input | 1 | Current-comparator trip |
| three_ph | input | 1 | 1 = three-phase rotation, 0 = two-phase rotation |
| ov_trip | input | 1 | Overvoltage comparator above trip point |
| ov_release | input | 1 | Output below overvoltage reset point |
| comp_low | input | 1 | Compensation node below disable level |
| vid | input | 5 | Voltage-ID code; all ones means no processor |
| pwm | output | 3 | Logic-level phase drive outputs, bit 0 is phase 1 |

## Verification
The assertions assume that every input is synchronous to `clk`, and that `tick` never stays high for two consecutive cycles. The "exactly one output high after a tick" property also assumes that no protection flag is active in the same cycle. The bench drives every input on the falling edge and holds `tick` high for one cycle per pulse. It releases `trip` and the protection flags before it expects phases to start again. The outputs are sampled just after the rising edge that registers each stimulus.

// File: rtl/mph_pkg.sv
package mph_pkg;
   localparam int unsigned MAX_PHASES = 8;

   function automatic int unsigned active_count(input logic hi, input int unsigned hi_n,
                                                input int unsigned lo_n);
      return hi ? hi_n : lo_n;
   endfunction
endpackage

// File: rtl/mph_guard.sv
module mph_guard #(
   parameter int unsigned VID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ov_trip,
   input  logic             ov_release,
   input  logic             comp_low,
   input  logic [VID_W-1:0] vid,
   output logic             inhibit,
   output logic             ov_held
);
   logic no_cpu;

   generate
      if (VID_W < 1) begin : g_bad_vid
         $error("mph_guard: VID_W must be at least 1");
      end
   endgenerate

   assign no_cpu = &vid;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ov_held <= 1'b0;
      else if (ov_trip)
         ov_held <= 1'b1;
      else if (ov_release)
         ov_held <= 1'b0;
   end

   assign inhibit = ov_trip | ov_held | comp_low | no_cpu;

   AST_OV_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_held && !ov_release) |=> ov_held) else $error("ov latch lost"); // R6
endmodule

// File: rtl/mph_ring.sv
module mph_ring #(
   parameter int unsigned NUM_PH = 3,
   parameter int unsigned LOW_PH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              sel_hi,
   output logic [NUM_PH-1:0] fire_oh,
   output logic              mode_o
);
   import mph_pkg::*;
   localparam int unsigned PW = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;

   logic [PW-1:0] nxt_q;
   logic [PW-1:0] fire_idx;
   logic [PW-1:0] last_idx;
   logic          mode_q;
   logic          restart;

   generate
      if (NUM_PH < 2 || NUM_PH > MAX_PHASES) begin : g_bad_n
         $error("mph_ring: NUM_PH out of range");
      end
      if (LOW_PH < 1 || LOW_PH > NUM_PH) begin : g_bad_low
         $error("mph_ring: LOW_PH out of range");
      end
   endgenerate

   assign restart  = (sel_hi != mode_q);
   assign fire_idx = restart ? '0 : nxt_q;
   assign last_idx = PW'(active_count(sel_hi, NUM_PH, LOW_PH) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_q  <= '0;
         mode_q <= 1'b0;
      end else if (adv) begin
         mode_q <= sel_hi;
         nxt_q  <= (fire_idx == last_idx) ? '0 : fire_idx + PW'(1);
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PH; gi++) begin : g_dec
         assign fire_oh[gi] = (fire_idx == PW'(gi));
      end
   endgenerate

   assign mode_o = mode_q;

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (nxt_q < PW'(LOW_PH))) else $error("pointer outside low mode"); // R2
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(mode_q)) else $error("mode changed off tick"); // R9
endmodule

// File: rtl/mph_cell.sv
module mph_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (set) q <= 1'b1;
   end
endmodule

// File: rtl/mph_sequencer.sv
module mph_sequencer #(
   parameter int unsigned NUM_PH = 3,
   parameter int unsigned LOW_PH = 2,
   parameter int unsigned VID_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              trip,
   input  logic              three_ph,
   input  logic              ov_trip,
   input  logic              ov_release,
   input  logic              comp_low,
   input  logic [VID_W-1:0]  vid,
   output logic [NUM_PH-1:0] pwm
);
   logic              inhibit;
   logic              ov_held;
   logic              tick_ok;
   logic              mode_q;
   logic [NUM_PH-1:0] fire_oh;

   mph_guard #(.VID_W(VID_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .ov_trip(ov_trip), .ov_release(ov_release),
      .comp_low(comp_low), .vid(vid), .inhibit(inhibit), .ov_held(ov_held)
   );

   assign tick_ok = tick & ~inhibit;

   mph_ring #(.NUM_PH(NUM_PH), .LOW_PH(LOW_PH)) u_ring (
      .clk(clk), .rst_n(rst_n), .adv(tick_ok), .sel_hi(three_ph),
      .fire_oh(fire_oh), .mode_o(mode_q)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PH; gi++) begin : g_ph
         logic set_i, clr_i;
         assign set_i = tick_ok & fire_oh[gi];
         assign clr_i = inhibit | (tick_ok & ~fire_oh[gi]) | (trip & ~tick_ok);
         mph_cell u_cell (.clk(clk), .rst_n(rst_n), .set(set_i), .clr(clr_i), .q(pwm[gi]));
      end
   endgenerate

   AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pwm)) else $error("overlapping phases"); // R4
   AST_TICK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ov_trip && !ov_held && !comp_low && !(&vid)) |=> ($countones(pwm) == 1))
      else $error("tick raised no phase"); // R1
   AST_TRIP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && !tick) |=> (pwm == '0)) else $error("trip ignored"); // R3
   AST_OV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ov_trip |=> (pwm == '0)) else $error("ov not forced low"); // R5
   AST_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      comp_low |=> (pwm == '0)) else $error("disable not honoured"); // R7
   AST_NOCPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (&vid) |=> (pwm == '0)) else $error("no-cpu not honoured"); // R8
   AST_TOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> !pwm[NUM_PH-1]) else $error("top phase in low mode"); // R2
endmodule

// File: tb/mph_sequencer_test.sv
`timescale 1ns/1ps
module mph_sequencer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, trip = 1'b0, three_ph = 1'b1;
   logic       ov_trip = 1'b0, ov_release = 1'b0, comp_low = 1'b0;
   logic [4:0] vid = 5'h0A;
   logic [2:0] pwm;
   int         n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   mph_sequencer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trip(trip), .three_ph(three_ph),
      .ov_trip(ov_trip), .ov_release(ov_release), .comp_low(comp_low),
      .vid(vid), .pwm(pwm)
   );

   task automatic check(input string req, input logic [2:0] exp);
      n_chk++;
      if (pwm !== exp) begin
         n_err++;
         $display("FAIL %s: pwm=%b expected %b", req, pwm, exp);
      end
   endtask

   // one clock: drive on falling edge, sample just after the rising edge
   task automatic step(input logic t, input logic tr);
      @(negedge clk);
      tick = t; trip = tr;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 0; trip = 0; ov_trip = 0; ov_release = 0; comp_low = 0;
      vid = 5'h0A;
      @(posedge clk); #1;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset();
      three_ph = 1'b1;
      do_reset();
      #1 check("R10 reset", 3'b000);
      step(1, 0); check("R10 first tick", 3'b001);
   endtask

   task automatic t_three();
      step(1, 0); check("R1 phase2", 3'b010);
      step(0, 0); check("R1 hold", 3'b010);
      step(1, 0); check("R1 phase3 R4 no overlap", 3'b100);
      step(1, 0); check("R1 wrap", 3'b001);
   endtask

   task automatic t_trip();
      step(0, 1); check("R3 trip clears", 3'b000);
      step(0, 0); check("R3 stays low", 3'b000);
      step(1, 1); check("R3 tick wins", 3'b010);
   endtask

   task automatic t_mode();
      three_ph = 1'b0;
      step(0, 0); check("R9 no change off tick", 3'b010);
      step(1, 0); check("R9 restart at phase1", 3'b001);
      step(1, 0); check("R2 phase2", 3'b010);
      step(1, 0); check("R2 wraps skip phase3", 3'b001);
      step(1, 0); check("R2 phase2 again", 3'b010);
      three_ph = 1'b1;
      step(1, 0); check("R9 back to three", 3'b001);
   endtask

   task automatic t_ov();
      @(negedge clk); ov_trip = 1'b1; tick = 0; trip = 0;
      @(posedge clk); #1; check("R5 ov forces low", 3'b000);
      step(1, 0); check("R5 tick ignored", 3'b000);
      @(negedge clk); ov_trip = 1'b0; tick = 0;
      @(posedge clk); #1;
      step(1, 0); check("R6 latched", 3'b000);
      @(negedge clk); ov_trip = 1'b1; ov_release = 1'b1; tick = 0;
      @(posedge clk); #1;
      @(negedge clk); ov_trip = 1'b0; ov_release = 1'b0;
      @(posedge clk); #1;
      step(1, 0); check("R6 release ignored under trip", 3'b000);
      @(negedge clk); ov_release = 1'b1; tick = 0;
      @(posedge clk); #1;
      @(negedge clk); ov_release = 1'b0;
      @(posedge clk); #1;
      step(1, 0); check("R6 resume due phase", 3'b010);
   endtask

   task automatic t_disable();
      @(negedge clk); comp_low = 1'b1; tick = 0;
      @(posedge clk); #1; check("R7 disable low", 3'b000);
      step(1, 0); check("R7 tick ignored", 3'b000);
      step(1, 0); check("R7 still low", 3'b000);
      @(negedge clk); comp_low = 1'b0; tick = 0;
      @(posedge clk); #1;
      step(1, 0); check("R7 rotation not advanced", 3'b100);
   endtask

   task automatic t_nocpu();
      @(negedge clk); vid = 5'b11111; tick = 0;
      @(posedge clk); #1; check("R8 no cpu low", 3'b000);
      step(1, 0); check("R8 tick blocked", 3'b000);
      @(negedge clk); vid = 5'b11110; tick = 0;
      @(posedge clk); #1;
      step(1, 0); check("R8 other code runs", 3'b001);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_three();
            t_trip();
            t_mode();
            t_ov();
            t_disable();
            t_nocpu();
            do_reset();
            #1 check("R10 reset clears latch", 3'b000);
            step(1, 0); check("R10 tick after reset", 3'b001);
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule